// File: doc/BRIEF.md
# Link Frame Builder

This block turns one 112-bit payload per bunch-crossing period into a fixed 128-bit link frame and presents it as eight 16-bit words, one per clock, ready for a 16:1 serializer. The payload is scrambled before it goes out. An 8-bit header in front of it and an 8-bit trailer behind it are sent in the clear, so 16 bits of overhead travel with every 112 payload bits.

The header has a fixed 2-bit sync marker, a 2-bit chunk index and one 4-bit slice of a 12-bit bunch-crossing counter. The counter advances once per frame. The slice sent cycles through the three nibbles of the counter, so a receiver rebuilds the whole counter from three consecutive headers. The trailer is a CRC-8 computed over the payload before scrambling. The scrambler is self-synchronizing, which lets a receiver recover its state from the bits it has received.

An upstream source pulses `pay_valid` with a payload once per 8-clock period. Back-to-back pulses give a continuous word stream with no idle gap. A synchronous `bcid_clr` restarts the counter.

Top module: `lfb_frame_builder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0, `out_idx` is 0 and `out_word` is 0.
- R2: A `pay_valid` sampled high on an accepting edge makes word 0 of its frame appear on the outputs after the second following edge (three edges in total, counting the accepting edge). Words 1 to 7 follow on consecutive cycles with `out_valid` high and `out_idx` counting 0 to 7.
- R3: The frame is the 128-bit value {header[7:0], scrambled payload[111:0], crc[7:0]}. Word k is frame bits [127-16k -: 16]. Word 0 therefore holds the header and the top 8 payload bits, and word 7 holds the last 8 payload bits and the trailer.
- R4: Header bits [7:6] are always 2'b10. Bits [5:4] hold a chunk index that goes 0, 1, 2, 0, ... on consecutive frames and is never 3.
- R5: Header bits [3:0] carry nibble `idx` of the 12-bit frame ID, where nibble `idx` is ID bits [4*idx+3 : 4*idx]. The ID starts at 0 after reset, rises by one per frame and wraps from 4095 to 0.
- R6: When `bcid_clr` is high on an edge, a frame accepted on that edge gets ID 0 and chunk index 0. When no frame is accepted on that edge, the next accepted frame gets ID 0 and chunk index 0.
- R7: Payload bits are scrambled MSB first. Each output bit is s = d XOR s(-6) XOR s(-7), where s(-n) is the scrambled bit sent n payload bits earlier. The scrambler history carries over from one frame's payload to the next and is all zero after reset.
- R8: The trailer is CRC-8 with polynomial 0x07, initial value 0x00, no reflection and no final XOR, computed MSB first over the unscrambled payload.
- R9: A `pay_valid` on any of the 7 edges after an accepting edge is ignored. The frame in flight and the following frames are unchanged, and the scrambler and ID are not advanced.
- R10: When no frame word is being presented, `out_valid` is 0 and `out_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (one frame per 8 cycles) |
| rst | input | 1 | Synchronous active-high reset |
| bcid_clr | input | 1 | Synchronous clear of the frame ID and chunk index |
| pay_valid | input | 1 | Payload strobe; starts a frame when accepted |
| pay_data | input | 112 | Payload bits, bit 111 sent first |
| out_valid | output | 1 | A frame word is on `out_word` |
| out_idx | output | 3 | Position of the current word within its frame |
| out_word | output | 16 | Frame word toward the serializer |

## Verification
The assertions check on every cycle:
- the fixed latency from an accepted strobe to word 0;
- the unbroken 0-to-7 word index;
- the sync marker and legal chunk index in every header;
- the zero idle word;
- the minimum 8-cycle spacing between accepted strobes.

The bench's scenarios are the only place the following can be seen:
- that the scrambled bits descramble to the payload sent, with the history carried across frames;
- that the trailer matches the CRC of the recovered payload;
- that the ID nibbles follow a counter through its wrap at 4095;
- that clearing, whether on its own or together with a strobe, restarts the ID.

// File: rtl/lfb_pkg.sv
`timescale 1ns/1ps
package lfb_pkg;
    localparam int PAY_W   = 112;
    localparam int WORD_W  = 16;
    localparam int HDR_W   = 8;
    localparam int CRC_W   = 8;
    localparam int ID_W    = 12;
    localparam int NIB_W   = 4;
    localparam int SCR_W   = 7;
    localparam int TAP_A   = 5;   // history bit holding s(-6)
    localparam int TAP_B   = 6;   // history bit holding s(-7)
    localparam int CIDX_W  = 2;
    localparam int FRAME_W = HDR_W + PAY_W + CRC_W;
    localparam int N_WORDS = FRAME_W / WORD_W;
    localparam int IDX_W   = $clog2(N_WORDS);
    localparam int N_NIB   = ID_W / NIB_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam logic [1:0]       SYNC_PAT = 2'b10;

    typedef struct packed {
        logic [1:0]        sync;
        logic [CIDX_W-1:0] cidx;
        logic [NIB_W-1:0]  nib;
    } hdr_t;

    typedef struct packed {
        hdr_t             hdr;
        logic [PAY_W-1:0] pay;
    } raw_t;

    typedef struct packed {
        hdr_t             hdr;
        logic [PAY_W-1:0] scr;
        logic [CRC_W-1:0] crc;
    } frame_t;

    typedef struct packed {
        logic [SCR_W-1:0] st;
        logic [PAY_W-1:0] dat;
    } scr_res_t;

    function automatic logic [CRC_W-1:0] crc_calc(input logic [PAY_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = PAY_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    function automatic scr_res_t scr_calc(input logic [SCR_W-1:0] st_in,
                                          input logic [PAY_W-1:0] d);
        scr_res_t         r;
        logic [SCR_W-1:0] h;
        logic             b;
        h     = st_in;
        r.dat = '0;
        for (int i = PAY_W - 1; i >= 0; i--) begin
            b        = d[i] ^ h[TAP_A] ^ h[TAP_B];
            r.dat[i] = b;
            h        = {h[SCR_W-2:0], b};
        end
        r.st = h;
        return r;
    endfunction
endpackage

// File: rtl/lfb_id_track.sv
`timescale 1ns/1ps
module lfb_id_track
    import lfb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic acc,
    output hdr_t hdr
);
    logic [ID_W-1:0]   id_q;
    logic [ID_W-1:0]   id_use;
    logic [CIDX_W-1:0] c_q;
    logic [CIDX_W-1:0] c_use;
    logic [NIB_W-1:0]  nib_sel [N_NIB];

    assign id_use = clr ? '0 : id_q;
    assign c_use  = clr ? '0 : c_q;

    generate
        for (genvar g = 0; g < N_NIB; g++) begin : g_nib
            assign nib_sel[g] = id_use[g*NIB_W +: NIB_W];
        end
    endgenerate

    always_comb begin
        hdr.sync = SYNC_PAT;
        hdr.cidx = c_use;
        hdr.nib  = '0;
        for (int g = 0; g < N_NIB; g++) begin
            if (c_use == CIDX_W'(g)) hdr.nib = nib_sel[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= '0;
            c_q  <= '0;
        end else if (acc) begin
            id_q <= id_use + 1'b1;
            c_q  <= (c_use == CIDX_W'(N_NIB - 1)) ? '0 : c_use + 1'b1;
        end else if (clr) begin
            id_q <= '0;
            c_q  <= '0;
        end
    end
endmodule

// File: rtl/lfb_scr_crc.sv
`timescale 1ns/1ps
module lfb_scr_crc
    import lfb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_vld,
    input  raw_t   in_raw,
    output logic   out_vld,
    output frame_t out_frm
);
    logic [SCR_W-1:0] st_q;
    scr_res_t         res;

    assign res = scr_calc(st_q, in_raw.pay);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            out_vld <= 1'b0;
            out_frm <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                st_q        <= res.st;
                out_frm.hdr <= in_raw.hdr;
                out_frm.scr <= res.dat;
                out_frm.crc <= crc_calc(in_raw.pay);
            end
        end
    end
endmodule

// File: rtl/lfb_word_out.sv
`timescale 1ns/1ps
module lfb_word_out
    import lfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  frame_t            frm,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic [WORD_W-1:0] out_word
);
    logic [FRAME_W-1:0] sh_q;
    logic [IDX_W-1:0]   idx_q;
    logic               vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
            vld_q <= 1'b0;
        end else if (ld) begin
            sh_q  <= frm;
            idx_q <= '0;
            vld_q <= 1'b1;
        end else if (vld_q) begin
            if (idx_q == IDX_W'(N_WORDS - 1)) begin
                sh_q  <= '0;
                idx_q <= '0;
                vld_q <= 1'b0;
            end else begin
                sh_q  <= sh_q << WORD_W;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_idx   = idx_q;
    assign out_word  = sh_q[FRAME_W-1 -: WORD_W];
endmodule

// File: rtl/lfb_frame_builder.sv
`timescale 1ns/1ps
module lfb_frame_builder
    import lfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bcid_clr,
    input  logic              pay_valid,
    input  logic [PAY_W-1:0]  pay_data,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic [WORD_W-1:0] out_word
);
    logic [IDX_W-1:0] gap_q;
    logic             acc;
    hdr_t             hdr;
    raw_t             a_q;
    logic             a_vld;
    logic             b_vld;
    frame_t           b_frm;

    assign acc = pay_valid && (gap_q == '0) && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
            a_vld <= 1'b0;
            a_q   <= '0;
        end else begin
            if (acc)               gap_q <= IDX_W'(N_WORDS - 1);
            else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
            a_vld <= acc;
            if (acc) begin
                a_q.hdr <= hdr;
                a_q.pay <= pay_data;
            end
        end
    end

    lfb_id_track u_id (
        .clk (clk),
        .rst (rst),
        .clr (bcid_clr),
        .acc (acc),
        .hdr (hdr)
    );

    lfb_scr_crc u_sc (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (a_vld),
        .in_raw  (a_q),
        .out_vld (b_vld),
        .out_frm (b_frm)
    );

    lfb_word_out u_wo (
        .clk       (clk),
        .rst       (rst),
        .ld        (b_vld),
        .frm       (b_frm),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_word  (out_word)
    );
endmodule

// File: rtl/lfb_frame_builder_chk.sv
`timescale 1ns/1ps
module lfb_frame_builder_chk
    import lfb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc,
    input logic              out_valid,
    input logic [IDX_W-1:0]  out_idx,
    input logic [WORD_W-1:0] out_word
);
    logic [IDX_W-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)                                 since_q <= IDX_W'(N_WORDS - 1);
        else if (acc)                            since_q <= '0;
        else if (since_q != IDX_W'(N_WORDS - 1)) since_q <= since_q + 1'b1;
    end

    // R2: fixed latency from accepted strobe to word 0
    p_first_word_r2: assert property (@(posedge clk) disable iff (rst)
        $past(acc, 3) |-> (out_valid && out_idx == '0));

    // R2: word index steps by one inside a frame
    p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx != IDX_W'(N_WORDS - 1)) |=>
        (out_valid && out_idx == IDX_W'($past(out_idx) + 1'b1)));

    // R4: sync marker and legal chunk index in every header
    p_hdr_sync_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx == '0) |->
        (out_word[15:14] == SYNC_PAT && out_word[13:12] != 2'b11));

    // R10: idle output is zero
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_word == '0);

    // R9: no acceptance within the 7 edges after an accepted strobe
    p_gap_r9: assert property (@(posedge clk) disable iff (rst)
        acc |-> since_q == IDX_W'(N_WORDS - 1));
endmodule

bind lfb_frame_builder lfb_frame_builder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_word  (out_word)
);

// File: tb/test_lfb_frame_builder.sv
`timescale 1ns/1ps
module test_lfb_frame_builder;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bcid_clr = 1'b0;
    logic         pay_valid = 1'b0;
    logic [111:0] pay_data = '0;
    logic         out_valid;
    logic [2:0]   out_idx;
    logic [15:0]  out_word;

    lfb_frame_builder i_lfb_frame_builder (
        .clk       (clk),
        .rst       (rst),
        .bcid_clr  (bcid_clr),
        .pay_valid (pay_valid),
        .pay_data  (pay_data),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_word  (out_word)
    );

    always #10 clk = ~clk;

    int edge_n = 0;
    always @(posedge clk) edge_n <= edge_n + 1;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int           m_gap = 0;
    int           m_id = 0;
    int           m_cidx = 0;
    logic [6:0]   m_hist = '0;
    logic [18:0]  exp_map [int];
    logic [111:0] sent_q [$];
    int           id_q [$];
    int           cid_q [$];
    bit           clr_q [$];
    logic [6:0]   rx_hist = '0;
    logic [127:0] rx_frame = '0;
    int           prev_id = -1;
    bit           saw_wrap = 1'b0;
    bit           saw_clr = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [111:0] d);
        logic [7:0] c;
        c = 8'h00;
        for (int i = 111; i >= 0; i--) begin
            if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [111:0] rnd();
        logic [127:0] r;
        r = {$urandom, $urandom, $urandom, $urandom};
        return r[111:0];
    endfunction

    // model of the edge that follows the current negedge
    task automatic model_edge();
        int           e;
        int           id;
        int           c;
        logic [7:0]   hdr;
        logic [111:0] s;
        logic [127:0] fr;
        logic         b;
        bit           acc;
        e   = edge_n + 1;
        acc = pay_valid && (m_gap == 0);
        if (acc) begin
            id  = bcid_clr ? 0 : m_id;
            c   = bcid_clr ? 0 : m_cidx;
            hdr = {2'b10, 2'(c), 4'((id >> (4 * c)) & 15)};
            for (int i = 111; i >= 0; i--) begin
                b      = pay_data[i] ^ m_hist[5] ^ m_hist[6];
                s[i]   = b;
                m_hist = {m_hist[5:0], b};
            end
            fr = {hdr, s, ref_crc(pay_data)};
            for (int k = 0; k < 8; k++) exp_map[e + 2 + k] = {3'(k), fr[127 - 16 * k -: 16]};
            sent_q.push_back(pay_data);
            id_q.push_back(id);
            cid_q.push_back(c);
            clr_q.push_back(bcid_clr == 1'b1 || (m_id == 0 && m_cidx == 0 && saw_clr));
            saw_clr = 1'b0;
            m_id    = (id + 1) % 4096;
            m_cidx  = (c == 2) ? 0 : c + 1;
            m_gap   = 7;
        end else begin
            if (bcid_clr) begin
                m_id    = 0;
                m_cidx  = 0;
                saw_clr = 1'b1;
            end
            if (m_gap > 0) m_gap--;
        end
    endtask

    task automatic frame_check();
        logic [111:0] desc;
        logic [111:0] exp_pay;
        logic         s;
        int           id;
        int           c;
        bit           was_clr;
        if (sent_q.size() == 0) begin
            check(1'b0, "R2 unexpected frame", 1, 0);
            return;
        end
        exp_pay = sent_q.pop_front();
        id      = id_q.pop_front();
        c       = cid_q.pop_front();
        was_clr = clr_q.pop_front();
        for (int i = 111; i >= 0; i--) begin
            s       = rx_frame[8 + i];
            desc[i] = s ^ rx_hist[5] ^ rx_hist[6];
            rx_hist = {rx_hist[5:0], s};
        end
        check(desc == exp_pay, "R7 descrambled payload", desc, exp_pay);
        check(rx_frame[7:0] == ref_crc(desc), "R8 trailer CRC", rx_frame[7:0], ref_crc(desc));
        check(rx_frame[127:126] == 2'b10, "R4 sync marker", rx_frame[127:126], 2'b10);
        check(rx_frame[125:124] == 2'(c), "R4 chunk index", rx_frame[125:124], 2'(c));
        check(rx_frame[123:120] == 4'((id >> (4 * c)) & 15), "R5 ID nibble",
              rx_frame[123:120], 4'((id >> (4 * c)) & 15));
        if (was_clr)
            check(rx_frame[125:120] == 6'd0, "R6 cleared header", rx_frame[125:120], 0);
        if (prev_id == 4095 && id == 0) saw_wrap = 1'b1;
        prev_id = id;
    endtask

    task automatic observe();
        logic [18:0] ex;
        if (exp_map.exists(edge_n)) begin
            ex = exp_map[edge_n];
            check(out_valid && out_idx == ex[18:16], "R2 word position",
                  {out_valid, out_idx}, {1'b1, ex[18:16]});
            check(out_word == ex[15:0], "R3 word content", out_word, ex[15:0]);
            exp_map.delete(edge_n);
        end else begin
            check(!out_valid && out_word == 16'h0, "R10 idle output",
                  {out_valid, out_word}, 0);
        end
        if (out_valid) begin
            rx_frame[127 - 16 * out_idx -: 16] = out_word;
            if (out_idx == 3'd7) frame_check();
        end
    endtask

    task automatic tick(input bit v, input logic [111:0] d, input bit clr);
        @(negedge clk);
        if (!rst) observe();
        pay_valid = v;
        pay_data  = d;
        bcid_clr  = clr;
        if (!rst) model_edge();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0 && out_idx == 3'd0 && out_word == 16'h0,
              "R1 reset state", {out_valid, out_idx, out_word}, 0);
        rst = 1'b0;
        tick(0, '0, 0);
        check(out_valid == 1'b0 && out_word == 16'h0, "R1 first cycle after reset",
              {out_valid, out_word}, 0);

        // R3 fixed patterns
        tick(1, '0, 0);
        repeat (7) tick(0, '0, 0);
        tick(1, '1, 0);
        repeat (7) tick(0, '0, 0);

        // R9: strobe held high with changing data; only every 8th edge accepts
        for (int f = 0; f < 8; f++)
            for (int k = 0; k < 8; k++) tick(1, rnd(), 0);

        // R10: idle gaps of varying length
        for (int f = 0; f < 6; f++) begin
            tick(1, rnd(), 0);
            repeat (7 + 3 * f) tick(0, '0, 0);
        end

        // R6: clear alone, then clear with a strobe, then clear while busy
        for (int f = 0; f < 4; f++) begin
            tick(1, rnd(), 0);
            repeat (7) tick(0, '0, 0);
        end
        tick(0, '0, 1);
        repeat (3) tick(0, '0, 0);
        for (int f = 0; f < 4; f++) begin
            tick(1, rnd(), 0);
            repeat (7) tick(0, '0, 0);
        end
        tick(1, rnd(), 1);
        repeat (7) tick(0, '0, 0);
        tick(1, rnd(), 0);
        tick(0, '0, 1);
        repeat (6) tick(0, '0, 0);
        tick(1, rnd(), 0);
        repeat (7) tick(0, '0, 0);

        // R5: long back-to-back run crossing the 4095 -> 0 wrap
        for (int f = 0; f < 4100; f++) begin
            tick(1, rnd(), 0);
            repeat (7) tick(0, rnd(), 0);
        end
        repeat (16) tick(0, '0, 0);

        check(saw_wrap, "R5 ID wrap 4095 to 0 observed", saw_wrap, 1);
        check(sent_q.size() == 0, "R2 every accepted frame delivered", sent_q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        #(64'd3000000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=finished", edge_n);
        summary();
        $finish;
    end
endmodule